// File: doc/BRIEF.md
# Bunch-Crossing Counter with Sync Check

This block keeps a local bunch-crossing number that steps once per bunch clock and returns to zero once per orbit. It raises a local BX0 flag whenever the number is zero. A resync command reloads the counter from a programmable offset input. An offset that falls outside the orbit loads zero instead.

Each received BX0 marker is compared with the local counter. If the local counter is not at zero when a received BX0 arrives, the block raises a one-cycle error pulse. The same comparison sets a sticky error flag, which holds until the next received BX0 is checked, so it covers a whole orbit. Software tunes the offset until this flag reads zero. A saturating counter tallies mismatches. A resync or a reset clears the flag, the pulse and the tally.

Top module: `bx_sync_counter`

## Requirements
- R1: After reset, the bunch-crossing number, the error pulse, the error flag and the error count are all zero.
- R2: With no resync, the bunch-crossing number rises by one each clock. It goes from ORBIT_LEN-1 to 0 and never holds a value of ORBIT_LEN or more.
- R3: The local BX0 output is 1 exactly in the cycles where the bunch-crossing number is 0.
- R4: When resync is sampled high, the number in the next cycle equals the offset input, provided the offset is below ORBIT_LEN. Counting then resumes from that value.
- R5: When resync is sampled high with an offset of ORBIT_LEN or more, the number in the next cycle is 0.
- R6: A received BX0 sampled while the number is not 0 makes the error pulse 1 for the following cycle only. At all other times the error pulse is 0.
- R7: Each received BX0 that is sampled without a resync updates the error flag. A nonzero number sets the flag to 1 and a zero number sets it to 0. Between received BX0 markers the flag holds its value.
- R8: Each mismatch as defined in R6 adds one to the error count in the following cycle. The count stops at 2^ERR_W-1.
- R9: When resync is sampled high, the pulse, the flag and the count all read 0 in the next cycle. A received BX0 sampled in the same cycle is not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync_i | input | 1 | Resync command, one cycle |
| bx0_rx_i | input | 1 | Received BX0 marker |
| offset_i | input | OFS_W | Value loaded into the counter on resync |
| bxn_o | output | CNT_W | Local bunch-crossing number |
| bx0_local_o | output | 1 | Local BX0, high when the number is 0 |
| sync_err_pulse_o | output | 1 | One-cycle mismatch pulse |
| sync_err_flag_o | output | 1 | Sticky mismatch flag, re-evaluated at each received BX0 |
| sync_err_count_o | output | ERR_W | Saturating mismatch count |

## Verification
The bench uses a 12-crossing orbit and a 4-bit offset. It tries every offset value from 0 to 15, which covers in-range loads and the out-of-range values that must load zero. For each offset, a received BX0 is placed at every orbit position, and each mismatch is followed by a matching BX0. This separates the pulse, which lasts one cycle, from the flag, which must persist through idle cycles and then clear on a match. A run of back-to-back received markers pushes the 4-bit count past its ceiling to show that it saturates. A resync that coincides with a received BX0 shows that the comparison is suppressed in that cycle.

// File: rtl/bxsync_pkg.sv
package bxsync_pkg;

    // Outcome state held by the comparison stage.
    typedef struct packed {
        logic pulse;
        logic flag;
    } sync_state_t;

    localparam sync_state_t SYNC_IDLE = '{pulse: 1'b0, flag: 1'b0};

endpackage

// File: rtl/bxn_counter.sv
module bxn_counter #(
    parameter int ORBIT_LEN = 3564,
    parameter int OFS_W     = 12,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resync_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [CNT_W-1:0] bxn_o,
    output logic             bx0_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] bxn;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       offset_ok;

    always_comb begin
        st_d      = st_q;
        offset_ok = (32'(offset_i) < 32'(ORBIT_LEN));
        if (resync_i) begin
            st_d.bxn = offset_ok ? CNT_W'(offset_i) : '0;
        end else if (st_q.bxn == LAST) begin
            st_d.bxn = '0;
        end else begin
            st_d.bxn = st_q.bxn + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bxn_o = st_q.bxn;
    assign bx0_o = (st_q.bxn == '0);

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_i && bxn_o == LAST) |=> (bxn_o == '0));
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_i && bxn_o != LAST) |=> (bxn_o == $past(bxn_o) + 1'b1));
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bxn_o) < 32'(ORBIT_LEN)));
    a_r5_oor_load: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_i && 32'(offset_i) >= 32'(ORBIT_LEN)) |=> bx0_o);

endmodule

// File: rtl/bx0_compare.sv
module bx0_compare
    import bxsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    input  logic bx0_rx_i,
    input  logic bx0_local_i,
    output logic mismatch_o,
    output logic pulse_o,
    output logic flag_o
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        mismatch_o = bx0_rx_i && !bx0_local_i && !resync_i;
        st_d.pulse = mismatch_o;
        if (resync_i) begin
            st_d = SYNC_IDLE;
        end else if (bx0_rx_i) begin
            st_d.flag = !bx0_local_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SYNC_IDLE;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign flag_o  = st_q.flag;

    a_r6_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> flag_o);
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !bx0_rx_i) |=> !pulse_o);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bx0_rx_i && !resync_i) |=> $stable(flag_o));
    a_r7_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bx0_rx_i && bx0_local_i) |=> !flag_o);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> (!flag_o && !pulse_o));

endmodule

// File: rtl/err_tally.sv
module err_tally #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [ERR_W-1:0] count_o
);
    localparam logic [ERR_W-1:0] TOP = '1;

    typedef struct packed {
        logic [ERR_W-1:0] count;
    } tally_state_t;

    tally_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.count = '0;
        end else if (inc_i && st_q.count != TOP) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && count_o == TOP) |=> (count_o == TOP));
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1));
    a_r9_tally_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

endmodule

// File: rtl/bx_sync_counter.sv
module bx_sync_counter #(
    parameter int ORBIT_LEN = 3564,
    parameter int OFS_W     = 12,
    parameter int ERR_W     = 16,
    localparam int CNT_W    = $clog2(ORBIT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resync_i,
    input  logic             bx0_rx_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [CNT_W-1:0] bxn_o,
    output logic             bx0_local_o,
    output logic             sync_err_pulse_o,
    output logic             sync_err_flag_o,
    output logic [ERR_W-1:0] sync_err_count_o
);
    logic mismatch;

    bxn_counter #(
        .ORBIT_LEN (ORBIT_LEN),
        .OFS_W     (OFS_W),
        .CNT_W     (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync_i (resync_i),
        .offset_i (offset_i),
        .bxn_o    (bxn_o),
        .bx0_o    (bx0_local_o)
    );

    bx0_compare u_compare (
        .clk         (clk),
        .rst_n       (rst_n),
        .resync_i    (resync_i),
        .bx0_rx_i    (bx0_rx_i),
        .bx0_local_i (bx0_local_o),
        .mismatch_o  (mismatch),
        .pulse_o     (sync_err_pulse_o),
        .flag_o      (sync_err_flag_o)
    );

    err_tally #(
        .ERR_W (ERR_W)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (resync_i),
        .inc_i   (mismatch),
        .count_o (sync_err_count_o)
    );

    // R8: pulse and count step together on every mismatch below saturation
    a_r8_pulse_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_pulse_o && !$past(resync_i) && $past(sync_err_count_o) != '1)
        |-> (sync_err_count_o != '0));
    // R3: local BX0 agrees with the published number
    a_r3_local_bx0: assert property (@(posedge clk) disable iff (!rst_n)
        (bx0_local_o == (bxn_o == '0)));

endmodule

// File: tb/bx_sync_counter_test.sv
module bx_sync_counter_test;
    localparam int ORB   = 12;
    localparam int OFS_W = 4;
    localparam int ERR_W = 4;
    localparam int CNT_W = $clog2(ORB);
    localparam int CMAX  = (1 << ERR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             resync = 1'b0;
    logic             bx0_rx = 1'b0;
    logic [OFS_W-1:0] offset = '0;
    logic [CNT_W-1:0] bxn;
    logic             bx0_local;
    logic             err_pulse;
    logic             err_flag;
    logic [ERR_W-1:0] err_count;

    int checks = 0;
    int errors = 0;
    int m_bxn = 0;
    int m_pulse = 0;
    int m_flag = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    bx_sync_counter #(.ORBIT_LEN(ORB), .OFS_W(OFS_W), .ERR_W(ERR_W)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .resync_i         (resync),
        .bx0_rx_i         (bx0_rx),
        .offset_i         (offset),
        .bxn_o            (bxn),
        .bx0_local_o      (bx0_local),
        .sync_err_pulse_o (err_pulse),
        .sync_err_flag_o  (err_flag),
        .sync_err_count_o (err_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string bxn_tag);
        check(bxn_tag, 32'(bxn), 32'(m_bxn));
        check("R3 local bx0", 32'(bx0_local), (m_bxn == 0) ? 32'd1 : 32'd0);
        check("R6 pulse", 32'(err_pulse), 32'(m_pulse));
        check("R7 flag", 32'(err_flag), 32'(m_flag));
        check("R8 count", 32'(err_count), 32'(m_cnt));
    endtask

    // One clock: apply inputs, advance the arithmetic model, compare at negedge.
    task automatic tick(input logic rs, input logic rx);
        string tag;
        resync = rs;
        bx0_rx = rx;
        @(posedge clk);
        tag = "R2 bxn";
        if (rs) begin
            if (int'(offset) < ORB) begin
                m_bxn = int'(offset);
                tag = "R4 bxn load";
            end else begin
                m_bxn = 0;
                tag = "R5 bxn out of range";
            end
            m_pulse = 0;
            m_flag  = 0;
            m_cnt   = 0;
        end else begin
            m_pulse = (rx && m_bxn != 0) ? 1 : 0;
            if (rx) m_flag = (m_bxn != 0) ? 1 : 0;
            if (m_pulse == 1 && m_cnt < CMAX) m_cnt++;
            m_bxn = (m_bxn == ORB - 1) ? 0 : m_bxn + 1;
        end
        @(negedge clk);
        resync = 1'b0;
        bx0_rx = 1'b0;
        check_all(tag);
        if (rs) begin
            check("R9 flag cleared", 32'(err_flag), 32'd0);
            check("R9 count cleared", 32'(err_count), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 bxn", 32'(bxn), 32'd0);
        check("R1 pulse", 32'(err_pulse), 32'd0);
        check("R1 flag", 32'(err_flag), 32'd0);
        check("R1 count", 32'(err_count), 32'd0);
        rst_n = 1'b1;

        // R2: free-run over more than two orbits
        for (int i = 0; i < 2 * ORB + 3; i++) tick(1'b0, 1'b0);

        // R4 R5 R6 R7: every offset, received BX0 at every orbit position
        for (int off = 0; off < (1 << OFS_W); off++) begin
            offset = OFS_W'(off);
            tick(1'b1, 1'b0);
            for (int k = 0; k < ORB; k++) begin
                while (m_bxn != k) tick(1'b0, 1'b0);
                tick(1'b0, 1'b1);
                // flag must persist through the rest of the orbit
                while (m_bxn != 0) tick(1'b0, 1'b0);
                // matching marker clears the flag
                tick(1'b0, 1'b1);
            end
        end

        // R8: back-to-back markers drive the count past its ceiling
        offset = OFS_W'(1);
        tick(1'b1, 1'b0);
        for (int i = 0; i < 3 * ORB; i++) tick(1'b0, 1'b1);
        check("R8 saturated", 32'(err_count), 32'(CMAX));

        // R9: resync together with a mismatching marker is not compared
        tick(1'b0, 1'b1);
        offset = OFS_W'(5);
        tick(1'b1, 1'b1);
        check("R9 no pulse", 32'(err_pulse), 32'd0);
        tick(1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule